// File: doc/BRIEF.md
# Multi-Queue Configuration Register File

This block holds the per-queue setup registers of a host controller that runs several circular command queues at once. Every queue slot has a submission side and a completion side, each with an attribute word, a 64-bit ring base split into a low and a high word, and a free configuration word. Software creates a queue by setting the enable bit of its attribute word and deletes it by clearing that bit. The block checks each such transition against the queues that already exist. A transition that passes the check updates the attribute word and the existence flag on the same clock edge. A transition that fails the check leaves both unchanged.

A submission queue is bound to the completion queue named in its attribute word when it is created. That binding stays fixed until the queue is deleted. A completion queue cannot be removed while any live submission queue is bound to it. For every slot, the block drives the pointer engine with the existence flags, the binding, the ring depth in entries and the ring base address.

The block also provides two read-only identification words and, for each slot, four read-only words that give the byte addresses of that slot's doorbell and interrupt-status registers in the runtime space. Register access is a single-port word bus. Reads are combinational. Writes take effect on the clock edge.

Top module: `qcfg_regfile`

## Requirements
- R1: After synchronous reset, every per-queue attribute, base and configuration word reads zero, no submission or completion queue is live, and both strobes are low.
- R2: Address 0x000 reads ACTIVE_Q-1 in bits 7:0, a 1 in bit 8 (round-robin arbitration), the value 2 in bits 23:16 and zero elsewhere. Address 0x004 reads 0x1F in bits 15:8 and zero elsewhere. Writes to either address leave the value unchanged and raise `unsup_o`.
- R3: Slot q occupies 64 bytes at 0x400 + 64*q. The words in a slot, by byte offset, are: 0x00 SQ attribute, 0x04 SQ base low, 0x08 SQ base high, 0x0C SQ config, 0x10 CQ attribute, 0x14 CQ base low, 0x18 CQ base high, 0x1C CQ config. Base and config words read back what was written. The base outputs are {high, low}.
- R4: Attribute fields are: enable in bit 31, bound-CQ index in bits 23:16 (SQ only), and SIZE in bits 15:0. A write that sets the SQ enable bit while it is clear creates the SQ. The create succeeds only if q < ACTIVE_Q, the SQ is not live, and the named CQ index is below MAX_Q and that CQ is live.
- R5: A write that clears the SQ enable bit while it is set deletes the SQ. The delete succeeds only if q < ACTIVE_Q and the SQ is live.
- R6: A write that sets the CQ enable bit while it is clear creates the CQ. The create succeeds only if q < ACTIVE_Q and the CQ is not live.
- R7: A write that clears the CQ enable bit while it is set deletes the CQ. The delete succeeds only if the CQ is live and no live SQ is bound to it.
- R8: When a create or delete fails, the attribute word and the live flag keep their previous values. An attribute write that leaves the enable bit unchanged is stored as written.
- R9: Each ring depth output equals ((SIZE+1)*4)/ENTRY_BYTES, using the current attribute word of that side.
- R10: Slot words at offsets 0x20, 0x24, 0x28 and 0x2C read 0x1000+48*q plus 0, 20, 28 and 36. These are the SQ doorbell, SQ interrupt status, CQ doorbell and CQ interrupt status. Writes to these words are ignored and raise `unsup_o`.
- R11: Unaligned addresses, the unused slot words 0x30 to 0x3C, and addresses outside both the identification words and the slot region read zero. Writes to them change nothing and raise `err_o`.
- R12: A live SQ keeps the binding captured at its creation. Later attribute writes that leave the enable bit set change the stored word but not the binding.
- R13: Each strobe is high for exactly the one cycle after the clock edge that accepted the triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| err_o | output | 1 | Pulse: write to an unmapped address |
| unsup_o | output | 1 | Pulse: write to a read-only word |
| sq_live_o | output | MAX_Q | Submission queue exists, one bit per slot |
| cq_live_o | output | MAX_Q | Completion queue exists, one bit per slot |
| sq_bind_o | output | MAX_Q*QID_W | Bound CQ index per submission queue |
| sq_depth_o | output | MAX_Q*DEPTH_W | SQ ring depth in entries per slot |
| cq_depth_o | output | MAX_Q*DEPTH_W | CQ ring depth in entries per slot |
| sq_base_o | output | MAX_Q*64 | SQ ring base address per slot |
| cq_base_o | output | MAX_Q*64 | CQ ring base address per slot |

## Verification
The assertions assume that the enable bit in each stored attribute word and the matching live flag start out equal after reset, and that only the register bus changes them. Because of this, every rising or falling edge of a live flag can be traced to a single validated write in the cycle before. They also assume one write per cycle, so a queue cannot be created and its completion target deleted on the same edge. The stimulus keeps to this by issuing every write from one task, spaced a full cycle apart. The random writes aim bound-CQ indices both inside and beyond MAX_Q and reach the slots at or above ACTIVE_Q, so that every reason for a rejection occurs alongside the successful transitions.

// File: rtl/qcfg_pkg.sv
package qcfg_pkg;

    localparam logic [31:0] SLOT_BASE    = 32'h400;
    localparam int unsigned SLOT_STRIDE  = 64;
    localparam logic [31:0] RT_BASE      = 32'h1000;
    localparam int unsigned RT_STRIDE    = 48;
    localparam int unsigned RT_SQ_IS_OFF = 20;
    localparam int unsigned RT_CQ_DB_OFF = 28;
    localparam int unsigned RT_CQ_IS_OFF = 36;
    localparam logic [7:0]  CFG_PTR      = 8'd2;
    localparam logic [7:0]  MAX_ACT_CMD  = 8'h1F;
    localparam int unsigned EN_BIT       = 31;

    typedef enum logic [3:0] {
        W_SQ_ATTR = 4'd0,  W_SQ_LO   = 4'd1,  W_SQ_HI   = 4'd2,  W_SQ_CFG  = 4'd3,
        W_CQ_ATTR = 4'd4,  W_CQ_LO   = 4'd5,  W_CQ_HI   = 4'd6,  W_CQ_CFG  = 4'd7,
        W_SQ_DBO  = 4'd8,  W_SQ_ISO  = 4'd9,  W_CQ_DBO  = 4'd10, W_CQ_ISO  = 4'd11,
        W_RSV12   = 4'd12, W_RSV13   = 4'd13, W_RSV14   = 4'd14, W_RSV15   = 4'd15
    } qword_e;

    typedef enum logic [1:0] {
        RG_NONE, RG_CAP, RG_MAXACT, RG_QUEUE
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] qidx;
        qword_e     word;
    } dec_t;

    function automatic logic attr_en(input logic [31:0] a);
        return a[EN_BIT];
    endfunction

    function automatic logic [7:0] attr_cqid(input logic [31:0] a);
        return a[23:16];
    endfunction

    function automatic logic [31:0] ring_depth(input logic [15:0] size,
                                               input int unsigned ebytes);
        logic [31:0] bytes;
        bytes = ({16'd0, size} + 32'd1) << 2;
        return bytes / ebytes;
    endfunction

    function automatic logic [31:0] rt_addr(input int unsigned q, input int unsigned off);
        return RT_BASE + 32'(q * RT_STRIDE) + 32'(off);
    endfunction

endpackage

// File: rtl/qcfg_decode.sv
module qcfg_decode
    import qcfg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MAX_Q  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [31:0] SLOT_END = SLOT_BASE + 32'(MAX_Q * SLOT_STRIDE);

    logic [31:0] a32;
    logic [31:0] off;

    always_comb begin
        a32 = 32'(addr);
        off = a32 - SLOT_BASE;
        dec = '{region: RG_NONE, qidx: 8'd0, word: W_SQ_ATTR};
        if (a32[1:0] == 2'b00) begin
            if (a32 == 32'h0) begin
                dec.region = RG_CAP;
            end else if (a32 == 32'h4) begin
                dec.region = RG_MAXACT;
            end else if (a32 >= SLOT_BASE && a32 < SLOT_END) begin
                dec.qidx = 8'(off >> 6);
                dec.word = qword_e'(off[5:2]);
                if (off[5:2] <= 4'd11) dec.region = RG_QUEUE;
            end
        end
    end
endmodule

// File: rtl/qcfg_xref.sv
module qcfg_xref #(
    parameter int MAX_Q = 8,
    parameter int QID_W = 3
) (
    input  logic [MAX_Q-1:0]       sq_live,
    input  logic [MAX_Q*QID_W-1:0] sq_bind,
    input  logic [MAX_Q-1:0]       cq_live,
    input  logic [7:0]             cqid_req,
    output logic                   cq_target_live,
    output logic [MAX_Q-1:0]       cq_bound
);
    always_comb begin
        cq_target_live = 1'b0;
        for (int c = 0; c < MAX_Q; c++) begin
            if (cqid_req == 8'(c)) cq_target_live = cq_live[c];
        end
    end

    always_comb begin
        for (int c = 0; c < MAX_Q; c++) begin
            cq_bound[c] = 1'b0;
            for (int s = 0; s < MAX_Q; s++) begin
                if (sq_live[s] && sq_bind[s*QID_W +: QID_W] == QID_W'(c))
                    cq_bound[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/qcfg_slot.sv
module qcfg_slot
    import qcfg_pkg::*;
#(
    parameter int QIDX        = 0,
    parameter int ACTIVE_Q    = 6,
    parameter int ENTRY_BYTES = 32,
    parameter int DEPTH_W     = 14,
    parameter int QID_W       = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  qword_e             word,
    input  logic [31:0]        wdata,
    input  logic               cq_target_live,
    input  logic               cq_bound,
    output logic               sq_live,
    output logic               cq_live,
    output logic [QID_W-1:0]   sq_bind,
    output logic [DEPTH_W-1:0] sq_depth,
    output logic [DEPTH_W-1:0] cq_depth,
    output logic [63:0]        sq_base,
    output logic [63:0]        cq_base,
    output logic [31:0]        rd_word
);
    localparam bit IN_RANGE = (QIDX < ACTIVE_Q);

    logic [31:0] sq_attr, sq_lo, sq_hi, sq_cfg;
    logic [31:0] cq_attr, cq_lo, cq_hi, cq_cfg;

    logic sq_wr, cq_wr, sq_rise, sq_fall, cq_rise, cq_fall;
    logic sq_mk_ok, sq_rm_ok, cq_mk_ok, cq_rm_ok, sq_take, cq_take;

    always_comb begin
        sq_wr    = wr && (word == W_SQ_ATTR);
        cq_wr    = wr && (word == W_CQ_ATTR);
        sq_rise  = !attr_en(sq_attr) &&  attr_en(wdata);
        sq_fall  =  attr_en(sq_attr) && !attr_en(wdata);
        cq_rise  = !attr_en(cq_attr) &&  attr_en(wdata);
        cq_fall  =  attr_en(cq_attr) && !attr_en(wdata);
        sq_mk_ok = IN_RANGE && !sq_live && cq_target_live;
        sq_rm_ok = IN_RANGE && sq_live;
        cq_mk_ok = IN_RANGE && !cq_live;
        cq_rm_ok = IN_RANGE && cq_live && !cq_bound;
        sq_take  = sq_wr && (sq_rise ? sq_mk_ok : (sq_fall ? sq_rm_ok : 1'b1));
        cq_take  = cq_wr && (cq_rise ? cq_mk_ok : (cq_fall ? cq_rm_ok : 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_attr <= '0; sq_lo <= '0; sq_hi <= '0; sq_cfg <= '0;
            cq_attr <= '0; cq_lo <= '0; cq_hi <= '0; cq_cfg <= '0;
            sq_live <= 1'b0;
            cq_live <= 1'b0;
            sq_bind <= '0;
        end else begin
            if (sq_take) begin
                sq_attr <= wdata;
                if (sq_rise) begin
                    sq_live <= 1'b1;
                    sq_bind <= QID_W'(attr_cqid(wdata));
                end else if (sq_fall) begin
                    sq_live <= 1'b0;
                end
            end
            if (cq_take) begin
                cq_attr <= wdata;
                if (cq_rise)      cq_live <= 1'b1;
                else if (cq_fall) cq_live <= 1'b0;
            end
            if (wr) begin
                case (word)
                    W_SQ_LO:  sq_lo  <= wdata;
                    W_SQ_HI:  sq_hi  <= wdata;
                    W_SQ_CFG: sq_cfg <= wdata;
                    W_CQ_LO:  cq_lo  <= wdata;
                    W_CQ_HI:  cq_hi  <= wdata;
                    W_CQ_CFG: cq_cfg <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign sq_depth = DEPTH_W'(ring_depth(sq_attr[15:0], ENTRY_BYTES));
    assign cq_depth = DEPTH_W'(ring_depth(cq_attr[15:0], ENTRY_BYTES));
    assign sq_base  = {sq_hi, sq_lo};
    assign cq_base  = {cq_hi, cq_lo};

    always_comb begin
        case (word)
            W_SQ_ATTR: rd_word = sq_attr;
            W_SQ_LO:   rd_word = sq_lo;
            W_SQ_HI:   rd_word = sq_hi;
            W_SQ_CFG:  rd_word = sq_cfg;
            W_CQ_ATTR: rd_word = cq_attr;
            W_CQ_LO:   rd_word = cq_lo;
            W_CQ_HI:   rd_word = cq_hi;
            W_CQ_CFG:  rd_word = cq_cfg;
            W_SQ_DBO:  rd_word = rt_addr(QIDX, 0);
            W_SQ_ISO:  rd_word = rt_addr(QIDX, RT_SQ_IS_OFF);
            W_CQ_DBO:  rd_word = rt_addr(QIDX, RT_CQ_DB_OFF);
            W_CQ_ISO:  rd_word = rt_addr(QIDX, RT_CQ_IS_OFF);
            default:   rd_word = 32'h0;
        endcase
    end

    // live flags mirror the stored enable bits (R8)
    assert_sq_live_en_R8: assert property (@(posedge clk) disable iff (rst)
        sq_live == attr_en(sq_attr));
    assert_cq_live_en_R8: assert property (@(posedge clk) disable iff (rst)
        cq_live == attr_en(cq_attr));
    // creation needed a live completion target (R4)
    assert_sq_create_target_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sq_live) |-> $past(cq_target_live));
    // slots beyond the active count never come alive (R6)
    assert_out_of_range_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (QIDX >= ACTIVE_Q) |-> !(sq_live || cq_live));
    // completion queue removed only when unbound (R7)
    assert_cq_delete_unbound_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cq_live) |-> !$past(cq_bound));
    // binding frozen while live (R12)
    assert_bind_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (sq_live && $past(sq_live)) |-> $stable(sq_bind));
endmodule

// File: rtl/qcfg_regfile.sv
module qcfg_regfile
    import qcfg_pkg::*;
#(
    parameter int MAX_Q       = 8,
    parameter int ACTIVE_Q    = 6,
    parameter int ENTRY_BYTES = 32,
    parameter int ADDR_W      = 12,
    localparam int QID_W      = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
    localparam int DEPTH_W    = $clog2((65536 * 4) / ENTRY_BYTES) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic                     err_o,
    output logic                     unsup_o,
    output logic [MAX_Q-1:0]         sq_live_o,
    output logic [MAX_Q-1:0]         cq_live_o,
    output logic [MAX_Q*QID_W-1:0]   sq_bind_o,
    output logic [MAX_Q*DEPTH_W-1:0] sq_depth_o,
    output logic [MAX_Q*DEPTH_W-1:0] cq_depth_o,
    output logic [MAX_Q*64-1:0]      sq_base_o,
    output logic [MAX_Q*64-1:0]      cq_base_o
);
    dec_t             dec;
    logic             cq_target_live;
    logic [MAX_Q-1:0] cq_bound;
    logic [31:0]      slot_rd [MAX_Q];
    logic             err_d, unsup_d;

    qcfg_decode #(.ADDR_W(ADDR_W), .MAX_Q(MAX_Q)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    qcfg_xref #(.MAX_Q(MAX_Q), .QID_W(QID_W)) u_xref (
        .sq_live        (sq_live_o),
        .sq_bind        (sq_bind_o),
        .cq_live        (cq_live_o),
        .cqid_req       (attr_cqid(wdata)),
        .cq_target_live (cq_target_live),
        .cq_bound       (cq_bound)
    );

    for (genvar q = 0; q < MAX_Q; q++) begin : g_slot
        logic slot_wr;
        assign slot_wr = wr_en && (dec.region == RG_QUEUE) && (dec.qidx == 8'(q));
        qcfg_slot #(
            .QIDX(q), .ACTIVE_Q(ACTIVE_Q), .ENTRY_BYTES(ENTRY_BYTES),
            .DEPTH_W(DEPTH_W), .QID_W(QID_W)
        ) u_slot (
            .clk            (clk),
            .rst            (rst),
            .wr             (slot_wr),
            .word           (dec.word),
            .wdata          (wdata),
            .cq_target_live (cq_target_live),
            .cq_bound       (cq_bound[q]),
            .sq_live        (sq_live_o[q]),
            .cq_live        (cq_live_o[q]),
            .sq_bind        (sq_bind_o[q*QID_W +: QID_W]),
            .sq_depth       (sq_depth_o[q*DEPTH_W +: DEPTH_W]),
            .cq_depth       (cq_depth_o[q*DEPTH_W +: DEPTH_W]),
            .sq_base        (sq_base_o[q*64 +: 64]),
            .cq_base        (cq_base_o[q*64 +: 64]),
            .rd_word        (slot_rd[q])
        );
    end

    always_comb begin
        rdata = 32'h0;
        case (dec.region)
            RG_CAP:    rdata = {8'h00, CFG_PTR, 7'h00, 1'b1, 8'(ACTIVE_Q - 1)};
            RG_MAXACT: rdata = {16'h0000, MAX_ACT_CMD, 8'h00};
            RG_QUEUE: begin
                for (int q = 0; q < MAX_Q; q++) begin
                    if (dec.qidx == 8'(q)) rdata = slot_rd[q];
                end
            end
            default: rdata = 32'h0;
        endcase
    end

    always_comb begin
        err_d   = wr_en && (dec.region == RG_NONE);
        unsup_d = wr_en && ((dec.region == RG_CAP) || (dec.region == RG_MAXACT) ||
                  ((dec.region == RG_QUEUE) && (dec.word >= W_SQ_DBO)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o   <= 1'b0;
            unsup_o <= 1'b0;
        end else begin
            err_o   <= err_d;
            unsup_o <= unsup_d;
        end
    end

    // strobes only follow an accepted write (R13)
    assert_strobe_follows_write_R13: assert property (@(posedge clk) disable iff (rst)
        (err_o || unsup_o) |-> $past(wr_en));
    // a write raises at most one strobe (R11)
    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(err_o && unsup_o));
endmodule

// File: tb/tb_qcfg_regfile.sv
module tb_qcfg_regfile;
    localparam int MAX_Q = 8;
    localparam int ACTIVE_Q = 6;
    localparam int EB = 32;
    localparam int ADDR_W = 12;
    localparam int QID_W = 3;
    localparam int DEPTH_W = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic err_o, unsup_o;
    logic [MAX_Q-1:0] sq_live_o, cq_live_o;
    logic [MAX_Q*QID_W-1:0] sq_bind_o;
    logic [MAX_Q*DEPTH_W-1:0] sq_depth_o, cq_depth_o;
    logic [MAX_Q*64-1:0] sq_base_o, cq_base_o;

    qcfg_regfile #(.MAX_Q(MAX_Q), .ACTIVE_Q(ACTIVE_Q), .ENTRY_BYTES(EB), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .err_o(err_o), .unsup_o(unsup_o), .sq_live_o(sq_live_o), .cq_live_o(cq_live_o),
        .sq_bind_o(sq_bind_o), .sq_depth_o(sq_depth_o), .cq_depth_o(cq_depth_o),
        .sq_base_o(sq_base_o), .cq_base_o(cq_base_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_sa[MAX_Q], m_sl[MAX_Q], m_sh[MAX_Q], m_sc[MAX_Q];
    logic [31:0] m_ca[MAX_Q], m_cl[MAX_Q], m_ch[MAX_Q], m_cc[MAX_Q];
    bit m_slive[MAX_Q], m_clive[MAX_Q];
    int m_bind[MAX_Q];
    bit x_err, x_unsup;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit m_bound(input int c);
        for (int s = 0; s < MAX_Q; s++)
            if (m_slive[s] && m_bind[s] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_depth(input logic [31:0] a);
        return ((32'(a[15:0]) + 32'd1) * 32'd4) / EB;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        int q, w;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 32'h0) return {8'h00, 8'h02, 7'h00, 1'b1, 8'(ACTIVE_Q - 1)};
        if (a == 32'h4) return 32'h0000_1F00;
        if (a < 32'h400 || a >= 32'h400 + MAX_Q * 64) return 32'h0;
        q = int'((a - 32'h400) >> 6);
        w = int'(a[5:2]);
        case (w)
            0: return m_sa[q];  1: return m_sl[q];  2: return m_sh[q];  3: return m_sc[q];
            4: return m_ca[q];  5: return m_cl[q];  6: return m_ch[q];  7: return m_cc[q];
            8: return 32'h1000 + 32'(48 * q);
            9: return 32'h1000 + 32'(48 * q + 20);
            10: return 32'h1000 + 32'(48 * q + 28);
            11: return 32'h1000 + 32'(48 * q + 36);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        int q, w, c;
        x_err = 1'b0; x_unsup = 1'b0;
        if (a[1:0] != 2'b00) begin x_err = 1'b1; return; end
        if (a == 32'h0 || a == 32'h4) begin x_unsup = 1'b1; return; end
        if (a < 32'h400 || a >= 32'h400 + MAX_Q * 64) begin x_err = 1'b1; return; end
        q = int'((a - 32'h400) >> 6);
        w = int'(a[5:2]);
        case (w)
            0: begin
                if (!m_sa[q][31] && d[31]) begin
                    c = int'(d[23:16]);
                    if (q < ACTIVE_Q && !m_slive[q] && c < MAX_Q && m_clive[c]) begin
                        m_sa[q] = d; m_slive[q] = 1'b1; m_bind[q] = c;
                    end
                end else if (m_sa[q][31] && !d[31]) begin
                    if (q < ACTIVE_Q && m_slive[q]) begin m_sa[q] = d; m_slive[q] = 1'b0; end
                end else m_sa[q] = d;
            end
            4: begin
                if (!m_ca[q][31] && d[31]) begin
                    if (q < ACTIVE_Q && !m_clive[q]) begin m_ca[q] = d; m_clive[q] = 1'b1; end
                end else if (m_ca[q][31] && !d[31]) begin
                    if (m_clive[q] && !m_bound(q)) begin m_ca[q] = d; m_clive[q] = 1'b0; end
                end else m_ca[q] = d;
            end
            1: m_sl[q] = d;  2: m_sh[q] = d;  3: m_sc[q] = d;
            5: m_cl[q] = d;  6: m_ch[q] = d;  7: m_cc[q] = d;
            8, 9, 10, 11: x_unsup = 1'b1;
            default: x_err = 1'b1;
        endcase
    endtask

    function automatic logic [31:0] qa(input int q, input int off);
        return 32'h400 + 32'(q * 64 + off);
    endfunction

    task automatic check_outputs(input string tag);
        for (int q = 0; q < MAX_Q; q++) begin
            check({tag, " sq_live R4 R5"}, 64'(sq_live_o[q]), 64'(m_slive[q]));
            check({tag, " cq_live R6 R7"}, 64'(cq_live_o[q]), 64'(m_clive[q]));
            if (m_slive[q]) check({tag, " bind R12"}, 64'(sq_bind_o[q*QID_W +: QID_W]), 64'(m_bind[q]));
            check({tag, " sq_depth R9"}, 64'(sq_depth_o[q*DEPTH_W +: DEPTH_W]), 64'(m_depth(m_sa[q])));
            check({tag, " cq_depth R9"}, 64'(cq_depth_o[q*DEPTH_W +: DEPTH_W]), 64'(m_depth(m_ca[q])));
            check({tag, " sq_base R3"}, sq_base_o[q*64 +: 64], {m_sh[q], m_sl[q]});
            check({tag, " cq_base R3"}, cq_base_o[q*64 +: 64], {m_ch[q], m_cl[q]});
        end
    endtask

    task automatic do_read(input logic [31:0] a, input string req);
        addr = ADDR_W'(a);
        #1;
        check(req, 64'(rdata), 64'(exp_read(a)));
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " err R11 R13"}, 64'(err_o), 64'(x_err));
        check({req, " unsup R10 R13"}, 64'(unsup_o), 64'(x_unsup));
        do_read(a, {req, " readback"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < MAX_Q; q++) begin
            m_sa[q] = 0; m_sl[q] = 0; m_sh[q] = 0; m_sc[q] = 0;
            m_ca[q] = 0; m_cl[q] = 0; m_ch[q] = 0; m_cc[q] = 0;
            m_slive[q] = 0; m_clive[q] = 0; m_bind[q] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 err", 64'(err_o), 64'd0);
        check("R1 unsup", 64'(unsup_o), 64'd0);
        check_outputs("R1");
        for (int q = 0; q < MAX_Q; q++) do_read(qa(q, 0), "R1 sq attr");
        // R2 identification words and read-only behaviour
        do_read(32'h0, "R2 cap");
        check("R2 cap literal", 64'(rdata), 64'h0002_0105);
        do_read(32'h4, "R2 maxact");
        do_write(32'h0, 32'hFFFF_FFFF, "R2 cap write");
        do_write(32'h4, 32'h0, "R2 maxact write");
        // R3 base words
        do_write(qa(2, 4), 32'hDEAD_0000, "R3 sq lo");
        do_write(qa(2, 8), 32'h0000_00AB, "R3 sq hi");
        do_write(qa(2, 12), 32'h1234_5678, "R3 sq cfg");
        check("R3 base", sq_base_o[2*64 +: 64], 64'h0000_00AB_DEAD_0000);
        // R4 SQ create on missing CQ fails (R8 keeps old attr)
        do_write(qa(1, 0), 32'h8001_001F, "R4 R8 sq no cq");
        check("R8 attr kept", 64'(rdata), 64'd0);
        // R6 create CQ1 with SIZE 0xFFFF -> depth 8192 (R9)
        do_write(qa(1, 16), 32'h8000_FFFF, "R6 cq create");
        check("R9 depth max", 64'(cq_depth_o[1*DEPTH_W +: DEPTH_W]), 64'd8192);
        // R4 SQ0 bound to CQ1, SIZE 0x1F -> depth 4
        do_write(qa(0, 0), 32'h8001_001F, "R4 sq create");
        check("R9 depth 4", 64'(sq_depth_o[0 +: DEPTH_W]), 64'd4);
        // R12 rewrite attribute naming another CQ keeps binding
        do_write(qa(0, 0), 32'h8003_0007, "R12 rebind attempt");
        check("R12 bind", 64'(sq_bind_o[0 +: QID_W]), 64'd1);
        // R7 delete of bound CQ fails
        do_write(qa(1, 16), 32'h0000_0000, "R7 bound delete");
        check("R7 cq still live", 64'(cq_live_o[1]), 64'd1);
        // R5 delete SQ0 then R7 delete CQ1
        do_write(qa(0, 0), 32'h0000_0000, "R5 sq delete");
        do_write(qa(1, 16), 32'h0000_0000, "R7 cq delete");
        check("R7 cq gone", 64'(cq_live_o[1]), 64'd0);
        // R6 out-of-range slot
        do_write(qa(6, 16), 32'h8000_0003, "R6 cq out of range");
        check("R6 slot6 idle", 64'(cq_live_o[6]), 64'd0);
        // R4 cqid beyond MAX_Q
        do_write(qa(2, 16), 32'h8000_0003, "R6 cq2 create");
        do_write(qa(3, 0), 32'h8009_0003, "R4 cqid too big");
        check("R4 sq3 idle", 64'(sq_live_o[3]), 64'd0);
        // R10 offset words
        do_read(qa(3, 32), "R10 sq db");
        check("R10 sq db literal", 64'(rdata), 64'h1090);
        do_read(qa(3, 44), "R10 cq is");
        check("R10 cq is literal", 64'(rdata), 64'h10B4);
        do_write(qa(3, 36), 32'h0, "R10 offset write");
        // R11 unmapped and unaligned
        do_write(32'h600, 32'h1, "R11 past slots");
        do_write(qa(0, 2), 32'h1, "R11 unaligned");
        do_write(qa(4, 48), 32'h1, "R11 reserved word");
        do_write(32'h100, 32'h1, "R11 gap");
        check_outputs("directed");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int q, w, c;
            logic [31:0] d, a;
            q = int'($urandom_range(MAX_Q - 1, 0));
            w = int'($urandom_range(15, 0));
            if (w >= 12 && $urandom_range(3, 0) != 0) w = 0;
            if (w == 1 || w == 2 || w == 3 || w >= 12) begin
                if ($urandom_range(1, 0) == 1) w = 4;
            end
            c = int'($urandom_range(9, 0));
            d = $urandom();
            if (w == 0 || w == 4) d = {d[31], 7'h0, 8'(c), 6'h0, d[9:0]};
            a = qa(q, w * 4);
            if ($urandom_range(49, 0) == 0) a = 32'(a) + 32'd1;
            do_write(a, d, "RND R8");
            if (i % 50 == 0) check_outputs("RND");
        end
        check_outputs("final");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule